// File: doc/BRIEF.md
# SPI4 Transmit Port Credit Manager

This block keeps the flow-control credit of every logical port on an SPI4 transmit link. Credit is counted in blocks of 16 bytes. Each port has a stored FIFO status code, a flag that marks that status as fresh or already consumed, and a remaining credit. A status receiver writes new status codes into the table. A port scheduler visits one port at a time and gives the number of blocks that port has waiting.

On each visit the block reads the port's entry. If the status is fresh, it applies the status rules to form the available credit. It grants a burst no larger than the credit or the pending count, whichever is smaller. It then writes back the remaining credit and marks the status as consumed, all in the same step. The result is presented one cycle later.

The port count and the credit width are parameters. The two burst limits come in as configuration inputs.

Top module: `spi4_credit_mgr`

## Requirements
- R1: After reset every port holds zero credit and a consumed status, and `rsp_valid` is low until the first visit.
- R2: A visit sampled with `svc_req` high gives `rsp_valid` high on the next cycle only. A cycle without a visit gives `rsp_valid` low on the next cycle.
- R3: The burst granted is the smaller of the available credit and `svc_pending`. The credit written back, shown on `rsp_credit`, is the available credit minus that burst, so it never goes below zero.
- R4: When the port's status is consumed (stale), the available credit is the stored credit and the stored status code has no effect.
- R5: A fresh status code 2'b00 (starving) sets the available credit to `cfg_maxburst1`, whatever credit remained.
- R6: A fresh status code 2'b01 (hungry) sets the available credit to the larger of `cfg_maxburst2` and the stored credit.
- R7: A fresh status code 2'b10 (satisfied) adds no credit: the available credit is the stored credit. Code 2'b11 is treated the same way.
- R8: A visit marks the port's status as consumed, so the next visit without a new status write takes the stale path of R4.
- R9: `rsp_grant` is high exactly when the granted burst is nonzero. A port with zero credit and stale status gets no grant, zero blocks and zero credit.
- R10: When a status write and a visit hit the same port in the same cycle, the visit uses the entry as it was before that cycle. The new code is stored as fresh and is applied at the next visit.
- R11: A status write changes only the addressed port. Of several writes to a port before a visit, only the last one counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_maxburst1 | input | CW | Credit granted on a fresh starving status |
| cfg_maxburst2 | input | CW | Credit floor on a fresh hungry status |
| stat_wr_en | input | 1 | Store a new status code for a port |
| stat_wr_port | input | PW | Port addressed by the status write |
| stat_wr_code | input | 2 | Status code (00 starving, 01 hungry, 10 satisfied, 11 as satisfied) |
| svc_req | input | 1 | Visit a port this cycle |
| svc_port | input | PW | Port being visited |
| svc_pending | input | CW | Blocks the visited port has waiting |
| rsp_valid | output | 1 | Visit result present |
| rsp_grant | output | 1 | Port may send a burst |
| rsp_blocks | output | CW | Blocks granted to the burst |
| rsp_credit | output | CW | Credit left after the burst |

## Verification
The status write and the visit's read-modify-write can land on the same port entry in the same cycle. The bench drives both on one port in a directed case and then many times in a random stream limited to eight ports. Its model applies the visit to the old entry and then lets the write set the code and the fresh flag. Every visit result is compared against the model, and so is the next visit to that port, which shows whether the written status survived the write-back.

// File: rtl/spi4cm_pkg.sv
package spi4cm_pkg;
   typedef enum logic [1:0] {
      ST_STARVING  = 2'b00,
      ST_HUNGRY    = 2'b01,
      ST_SATISFIED = 2'b10,
      ST_RESERVED  = 2'b11
   } fifo_stat_e;
endpackage

// File: rtl/spi4cm_table.sv
module spi4cm_table
   import spi4cm_pkg::*;
#(
   parameter int NPORTS = 256,
   parameter int CW     = 8,
   parameter int PW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_en,
   input  logic [PW-1:0]     sw_idx,
   input  fifo_stat_e        sw_code,
   input  logic              cw_en,
   input  logic [PW-1:0]     cw_idx,
   input  logic [CW-1:0]     cw_credit,
   input  logic [PW-1:0]     rd_idx,
   output logic [CW-1:0]     rd_credit,
   output fifo_stat_e        rd_stat,
   output logic              rd_fresh,
   output logic [NPORTS-1:0] upd_vec
);
   localparam int FULL = (NPORTS == (1 << PW)) ? 1 : 0;

   logic [CW-1:0] cred_q [NPORTS];
   fifo_stat_e    stat_q [NPORTS];
   logic          upd_q  [NPORTS];

   for (genvar i = 0; i < NPORTS; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cred_q[i] <= '0;
            stat_q[i] <= ST_SATISFIED;
            upd_q[i]  <= 1'b0;
         end else begin
            if (cw_en && cw_idx == PW'(i)) begin
               cred_q[i] <= cw_credit;
               upd_q[i]  <= 1'b0;
            end
            // the status write is placed last so it wins a same-entry clash
            if (sw_en && sw_idx == PW'(i)) begin
               stat_q[i] <= sw_code;
               upd_q[i]  <= 1'b1;
            end
         end
      end
      assign upd_vec[i] = upd_q[i];
   end

   if (FULL == 1) begin : g_rd_direct
      always_comb begin
         rd_credit = cred_q[rd_idx];
         rd_stat   = stat_q[rd_idx];
         rd_fresh  = upd_q[rd_idx];
      end
   end else begin : g_rd_guard
      always_comb begin
         rd_credit = '0;
         rd_stat   = ST_SATISFIED;
         rd_fresh  = 1'b0;
         if (int'(rd_idx) < NPORTS) begin
            rd_credit = cred_q[rd_idx];
            rd_stat   = stat_q[rd_idx];
            rd_fresh  = upd_q[rd_idx];
         end
      end
   end
endmodule

// File: rtl/spi4cm_calc.sv
module spi4cm_calc
   import spi4cm_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          fresh,
   input  fifo_stat_e    stat,
   input  logic [CW-1:0] credit,
   input  logic [CW-1:0] limit_starve,
   input  logic [CW-1:0] limit_hungry,
   input  logic [CW-1:0] pending,
   output logic [CW-1:0] avail,
   output logic [CW-1:0] burst,
   output logic [CW-1:0] remain,
   output logic          grant
);
   always_comb begin
      avail = credit;
      if (fresh) begin
         unique case (stat)
            ST_STARVING: avail = limit_starve;
            ST_HUNGRY:   avail = (limit_hungry > credit) ? limit_hungry : credit;
            default:     avail = credit;
         endcase
      end
   end

   always_comb begin
      burst  = (avail < pending) ? avail : pending;
      remain = avail - burst;
      grant  = (burst != '0);
   end
endmodule

// File: rtl/spi4_credit_mgr.sv
module spi4_credit_mgr
   import spi4cm_pkg::*;
#(
   parameter int NPORTS = 256,
   parameter int CW     = 8,
   localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_maxburst1,
   input  logic [CW-1:0] cfg_maxburst2,
   input  logic          stat_wr_en,
   input  logic [PW-1:0] stat_wr_port,
   input  logic [1:0]    stat_wr_code,
   input  logic          svc_req,
   input  logic [PW-1:0] svc_port,
   input  logic [CW-1:0] svc_pending,
   output logic          rsp_valid,
   output logic          rsp_grant,
   output logic [CW-1:0] rsp_blocks,
   output logic [CW-1:0] rsp_credit
);
   if (NPORTS < 2 || NPORTS > 256) begin : g_bad_ports
      $error("spi4_credit_mgr: NPORTS must lie in 2..256");
   end
   if (CW < 4 || CW > 16) begin : g_bad_width
      $error("spi4_credit_mgr: CW must lie in 4..16");
   end

   logic [CW-1:0]     rd_credit;
   fifo_stat_e        rd_stat;
   logic              rd_fresh;
   logic [NPORTS-1:0] upd_vec;
   logic [CW-1:0]     c_avail, c_burst, c_remain;
   logic              c_grant;

   spi4cm_table #(.NPORTS(NPORTS), .CW(CW), .PW(PW)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_en     (stat_wr_en),
      .sw_idx    (stat_wr_port),
      .sw_code   (fifo_stat_e'(stat_wr_code)),
      .cw_en     (svc_req),
      .cw_idx    (svc_port),
      .cw_credit (c_remain),
      .rd_idx    (svc_port),
      .rd_credit (rd_credit),
      .rd_stat   (rd_stat),
      .rd_fresh  (rd_fresh),
      .upd_vec   (upd_vec)
   );

   spi4cm_calc #(.CW(CW)) u_calc (
      .fresh        (rd_fresh),
      .stat         (rd_stat),
      .credit       (rd_credit),
      .limit_starve (cfg_maxburst1),
      .limit_hungry (cfg_maxburst2),
      .pending      (svc_pending),
      .avail        (c_avail),
      .burst        (c_burst),
      .remain       (c_remain),
      .grant        (c_grant)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_grant  <= 1'b0;
         rsp_blocks <= '0;
         rsp_credit <= '0;
      end else begin
         rsp_valid <= svc_req;
         if (svc_req) begin
            rsp_grant  <= c_grant;
            rsp_blocks <= c_burst;
            rsp_credit <= c_remain;
         end
      end
   end

   // R2: response appears exactly one cycle after a visit
   a_r2_resp_timing: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |=> rsp_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !svc_req |=> !rsp_valid);
   // R3: burst never exceeds what the port had pending
   a_r3_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |=> rsp_blocks <= $past(svc_pending));
   // R5: fresh starving status splits exactly the starving limit
   a_r5_starve_total: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_req && rd_fresh && rd_stat == ST_STARVING)
      |=> (rsp_blocks + rsp_credit) == $past(cfg_maxburst1));
   // R8: a visit leaves the port consumed unless a status write hit it
   a_r8_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_req && !(stat_wr_en && stat_wr_port == svc_port))
      |=> !upd_vec[$past(svc_port)]);
   // R9: stale port with no credit gets nothing
   a_r9_stale_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_req && !rd_fresh && rd_credit == '0)
      |=> (!rsp_grant && rsp_blocks == '0 && rsp_credit == '0));
   // R10: a colliding status write leaves the port fresh
   a_r10_clash_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_req && stat_wr_en && stat_wr_port == svc_port)
      |=> upd_vec[$past(svc_port)]);
endmodule

// File: tb/sim_spi4_credit_mgr.sv
module sim_spi4_credit_mgr;
   localparam int NP = 256;
   localparam int CW = 8;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_maxburst1 = '0;
   logic [CW-1:0] cfg_maxburst2 = '0;
   logic          stat_wr_en = 1'b0;
   logic [PW-1:0] stat_wr_port = '0;
   logic [1:0]    stat_wr_code = '0;
   logic          svc_req = 1'b0;
   logic [PW-1:0] svc_port = '0;
   logic [CW-1:0] svc_pending = '0;
   logic          rsp_valid, rsp_grant;
   logic [CW-1:0] rsp_blocks, rsp_credit;

   int checks = 0;
   int errors = 0;
   int m_cred [NP];
   int m_stat [NP];
   bit m_upd  [NP];
   int mb1 = 12;
   int mb2 = 6;
   int unsigned lfsr = 32'h1234_5678;

   always #4 clk = ~clk;

   spi4_credit_mgr #(.NPORTS(NP), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_maxburst1(cfg_maxburst1), .cfg_maxburst2(cfg_maxburst2),
      .stat_wr_en(stat_wr_en), .stat_wr_port(stat_wr_port), .stat_wr_code(stat_wr_code),
      .svc_req(svc_req), .svc_port(svc_port), .svc_pending(svc_pending),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
      .rsp_blocks(rsp_blocks), .rsp_credit(rsp_credit)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int rnd(input int n);
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      return int'(lfsr % n);
   endfunction

   // one cycle: drive at a falling edge, check at the next falling edge
   task automatic step(input bit se, input int sp, input int sc,
                       input bit rq, input int rp, input int pd, input string tag);
      int av, eb, ec;
      string t;
      bit eg;
      cfg_maxburst1 = CW'(mb1);
      cfg_maxburst2 = CW'(mb2);
      stat_wr_en    = se;
      stat_wr_port  = PW'(sp);
      stat_wr_code  = 2'(sc);
      svc_req       = rq;
      svc_port      = PW'(rp);
      svc_pending   = CW'(pd);
      av = m_cred[rp];
      t  = tag;
      if (m_upd[rp]) begin
         if (m_stat[rp] == 0) begin av = mb1; if (t == "") t = "R5"; end
         else if (m_stat[rp] == 1) begin
            if (mb2 > av) av = mb2;
            if (t == "") t = "R6";
         end else if (t == "") t = "R7";
      end else if (t == "") t = "R4";
      eb = (av < pd) ? av : pd;
      ec = av - eb;
      eg = (eb != 0);
      if (rq) begin m_cred[rp] = ec; m_upd[rp] = 1'b0; end
      if (se) begin m_stat[sp] = sc; m_upd[sp] = 1'b1; end
      @(negedge clk);
      chk(rsp_valid == rq, "R2", "rsp_valid", int'(rsp_valid), int'(rq));
      if (rq) begin
         chk(rsp_grant == eg, t, "grant (R9)", int'(rsp_grant), int'(eg));
         chk(int'(rsp_blocks) == eb, t, "blocks (R3)", int'(rsp_blocks), eb);
         chk(int'(rsp_credit) == ec, t, "credit (R3)", int'(rsp_credit), ec);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < NP; i++) begin m_cred[i] = 0; m_stat[i] = 2; m_upd[i] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
      step(0, 0, 0, 1, 5, 4, "R1");                  // empty port, no grant
      step(0, 0, 0, 1, 200, 9, "R1");
      // starving then stale drain
      step(1, 1, 0, 0, 0, 0, "R5");
      step(0, 0, 0, 1, 1, 4, "R5");                  // 12 -> burst 4, left 8
      step(0, 0, 0, 1, 1, 20, "R4");                 // stale: burst 8, left 0
      step(0, 0, 0, 1, 1, 3, "R9");                  // stale, zero: nothing
      // hungry below and above the floor
      step(1, 2, 1, 0, 0, 0, "R6");
      step(0, 0, 0, 1, 2, 2, "R6");                  // max(6,0)=6 -> left 4
      step(1, 2, 1, 1, 3, 0, "R6");
      step(0, 0, 0, 1, 2, 0, "R9");                  // max(6,4)=6, zero pending
      step(1, 3, 0, 0, 0, 0, "R5");
      step(0, 0, 0, 1, 3, 1, "R5");                  // 12 -> 11
      step(1, 3, 1, 0, 0, 0, "R6");
      step(0, 0, 0, 1, 3, 1, "R6");                  // max(6,11)=11 -> 10
      // satisfied and code 11 add nothing
      step(1, 3, 2, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 3, 3, "R7");                  // 10 -> 7
      step(1, 3, 3, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 3, 2, "R7");                  // 7 -> 5
      // consumed status is not applied twice
      step(1, 4, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 1, 4, 1, "R8");                  // 12 -> 11
      step(0, 0, 0, 1, 4, 1, "R8");                  // stays stale: 11 -> 10
      // same-cycle write and visit
      step(1, 5, 0, 0, 0, 0, "R10");
      step(0, 0, 0, 1, 5, 2, "R10");                 // 12 -> 10
      step(1, 5, 0, 1, 5, 3, "R10");                 // uses stale 10 -> 7
      step(0, 0, 0, 1, 5, 0, "R10");                 // new starving: 12
      // last write wins, other ports untouched
      step(1, 6, 0, 0, 0, 0, "R11");
      step(1, 6, 2, 0, 0, 0, "R11");
      step(0, 0, 0, 1, 6, 1, "R11");                 // satisfied, zero credit
      step(0, 0, 0, 1, 7, 1, "R11");
      // random stream over eight ports to force clashes
      for (int n = 0; n < 3000; n++) begin
         if (rnd(64) == 0) begin mb1 = rnd(256); mb2 = rnd(256); end
         step(rnd(3) != 0, rnd(8), rnd(4), rnd(4) != 0, rnd(8), rnd(40), "");
      end
      step(0, 0, 0, 0, 0, 0, "R2");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule